// File: doc/BRIEF.md
# Configurable 2/3-Wire Serial Shifter

This block moves one short frame of serial data per request between a host and a peer. It can use separate data-out and data-in wires next to a clock (3-wire), or a single shared data line next to the clock (2-wire). It generates the line clock itself from the 4.5 MHz system clock, at one of four rates, or it follows a clock supplied by the peer.

The host sets the configuration inputs, places a byte on `tx_data` and pulses `start`. The block shifts out 4 or 8 bits in the chosen order while it collects the same number of bits from the line. At the end it pulses `done`, and also `irq` when interrupts are enabled. Each pin of the clock and data lines has a value and an output enable, so the pad ring can build push-pull or open-drain drivers. An open-drain line is pulled high outside the block.

Top module: `ser_shifter`

## Requirements
- R1: After reset, `busy`, `done` and `irq` are low and `rx_data` is 0.
- R2: With `cfg_len8`=1 a frame has 8 bits; with `cfg_len8`=0 it has 4 bits, taken from `tx_data[3:0]`. `busy` rises on the cycle after an accepted `start`. It falls in the same cycle as the single-cycle `done` pulse that follows the last bit.
- R3: With `cfg_lsb_first`=0, bit N-1 goes out first; with 1, bit 0 goes out first (N is the frame length). Each received bit lands at the bit position it had at the sender. In 4-bit frames `rx_data[7:4]` is 0.
- R4: With `cfg_ext_clk`=0, each half period of the line clock lasts 5, 10, 15 or 30 system clocks for `cfg_rate` 0, 1, 2 or 3. An 8-bit frame therefore lasts 16 half periods from `start` to `done`.
- R5: With `cfg_edge_fall`=0 the clock idles low and the active edge is rising; with 1 it idles high and the active edge is falling. Output data changes on the inactive edge, and input data is sampled on the active edge.
- R6: With `cfg_ext_clk`=1, bits advance on edges of `sck_i`, and `sck_oe` stays low.
- R7: With `cfg_two_wire`=1, input bits are read from `sdio_in`. The data output is open-drain: `sd_oe` is high only while a 0 is sent, and `sd_out` is always 0.
- R8: With `cfg_open_drain`=1 in 3-wire mode, both the data output and the generated clock are open-drain. Each is enabled only to drive a 0.
- R9: `irq` pulses together with `done` when `irq_en`=1 and stays low when `irq_en`=0.
- R10: A `start` pulse while `busy` is high is ignored. The current frame, its data and its timing are unaffected, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4.5 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 1: follow `sck_i`; 0: generate the clock |
| cfg_rate | input | 2 | Generated clock rate select |
| cfg_edge_fall | input | 1 | 1: falling edge is active, clock idles high |
| cfg_len8 | input | 1 | 1: 8-bit frame; 0: 4-bit frame |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_two_wire | input | 1 | 1: shared data line mode |
| cfg_open_drain | input | 1 | 1: open-drain clock and data in 3-wire mode |
| irq_en | input | 1 | Enables `irq` |
| start | input | 1 | Starts a frame when idle |
| tx_data | input | 8 | Data to send, sampled at an accepted start |
| rx_data | output | 8 | Received data, valid after `done` |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Single-cycle end-of-frame pulse |
| irq | output | 1 | Interrupt request pulse |
| sck_i | input | 1 | External line clock |
| sck_o | output | 1 | Generated line clock value |
| sck_oe | output | 1 | Generated line clock enable |
| sd_in | input | 1 | 3-wire data input |
| sdio_in | input | 1 | 2-wire shared line as seen at the pad |
| sd_out | output | 1 | Data output value |
| sd_oe | output | 1 | Data output enable |

## Verification
The checks assume that the configuration inputs change only while `busy` is low. They also assume that an external clock has half periods of several system clocks, because edges of `sck_i` are seen through a two-flop synchronizer. The stimulus sets each configuration and then idles a few cycles before `start`. In slave runs it holds `sck_i` at each level for twelve system clocks. The modelled peer changes its data bit only on an inactive edge, so input data is always stable around the active edge.

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int HALF_BASE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_ext_clk,
  input  logic [1:0] cfg_rate,
  input  logic       cfg_edge_fall,
  input  logic       cfg_len8,
  input  logic       cfg_lsb_first,
  input  logic       cfg_two_wire,
  input  logic       cfg_open_drain,
  input  logic       irq_en,
  input  logic       start,
  input  logic [7:0] tx_data,
  output logic [7:0] rx_data,
  output logic       busy,
  output logic       done,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sd_in,
  input  logic       sdio_in,
  output logic       sd_out,
  output logic       sd_oe
);
  localparam int HMAX = HALF_BASE * 6;
  localparam int CW = $clog2(HMAX);

  logic [2:0]    sck_s;
  logic [1:0]    din_s;
  logic [CW-1:0] hcnt, half_lim;
  logic [2:0]    bitcnt;
  logic [7:0]    txs, rxs;
  logic          lvl;

  always_comb begin
    case (cfg_rate)
      2'd0:    half_lim = CW'(HALF_BASE - 1);
      2'd1:    half_lim = CW'(HALF_BASE * 2 - 1);
      2'd2:    half_lim = CW'(HALF_BASE * 3 - 1);
      default: half_lim = CW'(HMAX - 1);
    endcase
  end

  wire din_raw  = cfg_two_wire ? sdio_in : sd_in;
  wire ext_act  = sck_s[1] ^ cfg_edge_fall;
  wire ext_prev = sck_s[2] ^ cfg_edge_fall;
  wire m_tick   = busy & ~cfg_ext_clk & (hcnt == half_lim);
  wire ev_act   = cfg_ext_clk ? (busy & ext_act & ~ext_prev) : (m_tick & ~lvl);
  wire ev_idle  = cfg_ext_clk ? (busy & ~ext_act & ext_prev) : (m_tick & lvl);
  wire last_bit = bitcnt == (cfg_len8 ? 3'd7 : 3'd3);
  wire txbit    = cfg_lsb_first ? txs[0] : (cfg_len8 ? txs[7] : txs[3]);
  wire od_data  = cfg_two_wire | cfg_open_drain;
  wire sck_lvl  = lvl ^ cfg_edge_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      din_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      din_s <= {din_s[0], din_raw};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      lvl    <= 1'b0;
      hcnt   <= '0;
      bitcnt <= '0;
      txs    <= '0;
      rxs    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        txs    <= tx_data;
        rxs    <= '0;
        bitcnt <= '0;
        lvl    <= 1'b0;
        hcnt   <= '0;
      end else if (busy) begin
        if (!cfg_ext_clk) begin
          hcnt <= m_tick ? '0 : hcnt + 1'b1;
          if (m_tick) lvl <= ~lvl;
        end
        if (ev_act) begin
          if (!cfg_lsb_first) rxs <= {rxs[6:0], din_s[1]};
          else if (cfg_len8)  rxs <= {din_s[1], rxs[7:1]};
          else                rxs <= {4'b0, din_s[1], rxs[3:1]};
        end
        if (ev_idle) begin
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            txs    <= cfg_lsb_first ? {1'b0, txs[7:1]} : {txs[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign rx_data = rxs;
  assign irq     = done & irq_en;
  assign sd_out  = od_data ? 1'b0 : txbit;
  assign sd_oe   = od_data ? (busy & ~txbit) : 1'b1;
  assign sck_o   = cfg_open_drain ? 1'b0 : sck_lvl;
  assign sck_oe  = cfg_ext_clk ? 1'b0 : (cfg_open_drain ? ~sck_lvl : 1'b1);
endmodule

// File: rtl/ser_shifter_chk.sv
module ser_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_ext_clk,
  input logic       cfg_edge_fall,
  input logic       cfg_two_wire,
  input logic       cfg_open_drain,
  input logic       irq_en,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       irq,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       sd_out,
  input logic       sd_oe
);
  a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && irq_en));

  a_r6_slave_releases_clock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_clk |-> !sck_oe);

  a_r7_data_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_two_wire || cfg_open_drain) && busy && sd_oe) |-> !sd_out);

  a_r5_idle_clock_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_ext_clk && !cfg_open_drain) |-> (sck_oe && sck_o == cfg_edge_fall));
endmodule

bind ser_shifter ser_shifter_chk i_chk (.*);

// File: tb/test_ser_shifter.sv
module test_ser_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int HS = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic c_ext = 0, c_fall = 0, c_len8 = 1, c_lsb = 0, c_two = 0, c_od = 0, c_ien = 0;
  logic [1:0] c_rate = 0;
  logic start = 0;
  logic [7:0] tx_data = 0;
  logic [7:0] rx_data;
  logic busy, done, irq, sck_o, sck_oe, sd_out, sd_oe;
  logic sck_i = 0;
  logic peer = 1;
  int checks = 0, failures = 0;
  bit finished = 0;

  bit         exp_bits[$];
  bit         peer_q[$];
  logic [7:0] exp_rx[$];
  bit         exp_irq[$];

  wire sd_line  = (sd_oe ? sd_out : 1'b1) & (c_two ? peer : 1'b1);
  wire sck_line = c_ext ? sck_i : (sck_oe ? sck_o : 1'b1);

  always #(CLK_PERIOD / 2) clk = ~clk;

  ser_shifter i_ser_shifter (
    .clk(clk), .rst_n(rst_n), .cfg_ext_clk(c_ext), .cfg_rate(c_rate),
    .cfg_edge_fall(c_fall), .cfg_len8(c_len8), .cfg_lsb_first(c_lsb),
    .cfg_two_wire(c_two), .cfg_open_drain(c_od), .irq_en(c_ien),
    .start(start), .tx_data(tx_data), .rx_data(rx_data), .busy(busy),
    .done(done), .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sd_in(peer), .sdio_in(sd_line), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic prev_act = 0;
  always @(negedge clk) begin
    logic a;
    a = sck_line ^ c_fall;
    if (rst_n && busy && a && !prev_act) begin
      if (exp_bits.size() == 0) chk("R2 extra active edge", 1, 0);
      else chk("R3/R5 line bit", sd_line, exp_bits.pop_front());
      if (c_two || c_od) chk("R7/R8 open-drain drive", sd_oe && sd_out, 0);
    end
    if (rst_n && busy && !a && prev_act && peer_q.size() > 0) peer <= peer_q.pop_front();
    if (rst_n && done) begin
      if (exp_rx.size() == 0) chk("R10 unexpected done", 1, 0);
      else begin
        chk("R3 rx_data", rx_data, exp_rx.pop_front());
        chk("R9 irq", irq, exp_irq.pop_front());
        chk("R2 bits all sent", exp_bits.size(), 0);
      end
    end
    prev_act = a;
  end

  task automatic run(input bit ext, input bit two, input bit od, input bit len8,
                     input bit lsb, input bit fall, input bit ien, input logic [1:0] rate,
                     input logic [7:0] tx, input logic [7:0] pw, input bit retry);
    int n, cnt, mult;
    logic [7:0] erx;
    n = len8 ? 8 : 4;
    erx = 0;
    @(negedge clk);
    c_ext = ext; c_two = two; c_od = od; c_len8 = len8; c_lsb = lsb;
    c_fall = fall; c_ien = ien; c_rate = rate; sck_i = fall;
    repeat (5) @(negedge clk);
    if (!ext) chk("R5 idle clock level", sck_line, fall);
    else chk("R6 clock released", sck_oe, 0);
    for (int i = 0; i < n; i++) begin
      int pos;
      bit tb, pb, lb;
      pos = lsb ? i : n - 1 - i;
      tb = tx[pos];
      pb = pw[pos];
      lb = two ? (tb & pb) : tb;
      exp_bits.push_back(lb);
      erx[pos] = two ? lb : pb;
      if (i == 0) peer = pb;
      else peer_q.push_back(pb);
    end
    exp_rx.push_back(erx);
    exp_irq.push_back(ien);
    start = 1; tx_data = tx;
    @(negedge clk);
    start = 0;
    cnt = 0;
    if (!ext) begin
      while (!done && cnt < 6000) begin
        @(negedge clk);
        cnt++;
        if (retry && cnt == 7) begin start = 1; tx_data = ~tx; end
        if (retry && cnt == 8) start = 0;
      end
      mult = (rate == 0) ? 1 : (rate == 1) ? 2 : (rate == 2) ? 3 : 6;
      chk("R4 frame duration", cnt, 2 * n * 5 * mult);
    end else begin
      for (int i = 0; i < n; i++) begin
        repeat (HS) @(posedge clk);
        #1 sck_i = ~fall;
        repeat (HS) @(posedge clk);
        #1 sck_i = fall;
      end
      while (!done && cnt < 50) begin @(negedge clk); cnt++; end
      chk("R6 slave frame ends", done, 1);
    end
    repeat (40) @(negedge clk);
    chk("R10 no extra frame", busy, 0);
    chk("R2 rx consumed", exp_rx.size(), 0);
    peer_q.delete();
    exp_bits.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    chk("R1 irq at reset", irq, 0);
    chk("R1 rx_data at reset", rx_data, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    // ext two od len8 lsb fall ien rate tx pw retry
    run(0, 0, 0, 1, 0, 0, 1, 2'd0, 8'hA5, 8'h3C, 0);
    run(0, 0, 0, 1, 1, 1, 0, 2'd1, 8'h96, 8'h1E, 0);
    run(0, 0, 0, 0, 0, 0, 1, 2'd2, 8'hFB, 8'hF5, 0);
    run(0, 0, 0, 0, 1, 1, 1, 2'd3, 8'h06, 8'h09, 0);
    run(1, 0, 0, 1, 0, 0, 1, 2'd0, 8'hC3, 8'h5A, 0);
    run(1, 0, 0, 0, 1, 1, 0, 2'd0, 8'h0D, 8'h02, 0);
    run(0, 1, 0, 1, 0, 0, 1, 2'd0, 8'hFF, 8'h81, 0);
    run(0, 1, 0, 1, 1, 1, 1, 2'd1, 8'h0F, 8'hFF, 0);
    run(0, 0, 1, 1, 0, 1, 0, 2'd0, 8'h5C, 8'hA3, 0);
    run(0, 0, 0, 1, 0, 0, 1, 2'd0, 8'h4E, 8'h71, 1);
    run(1, 1, 0, 1, 0, 1, 1, 2'd0, 8'hF0, 8'hCC, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule